// File: doc/BRIEF.md
# I/Q Correction Multiplier Stage

This block corrects one channel of a complex I/Q pair with fixed-point arithmetic. An elaboration parameter fixes the variant. In scale-and-offset form, the channel's own sample is multiplied by a gain coefficient and a signed offset is then added. In matrix form, the result is the sum of the I sample times the first coefficient and the Q sample times the second coefficient. Gain and matrix coefficients are signed values in 1.1.14 format: a sign bit, one integer bit and fourteen fraction bits, so 0x4000 is unity.

A complex pair uses two instances. The even channel is the master and the odd channel is the slave. Each instance takes its own sample and its partner's sample. The parity parameter decides which of the two is I and which is Q. Coefficients are captured together when the enable input rises, so software can reload both words without exposing a half-updated pair. While enable is low, samples pass through unchanged with the same latency.

Top module: `iqc_stage`

## Requirements
- R1: A sample accepted with `s_valid` high at clock edge k appears on `m_data` with `m_valid` high after edge k+1. `m_valid` is high only in that case, for exactly one cycle per accepted sample, and back-to-back samples stream with no gaps.
- R2: While no new result arrives, `m_data` keeps its last value, whatever the sample inputs do.
- R3: When `enable` is low as the sample is accepted, `m_data` equals `s_own` bit for bit.
- R4: In scale-and-offset mode (`MODE` = IQC_SCALE_OFF), the result is floor(own × coef_1 / 2^14) + coef_2. Here coef_1 is 1.1.14 and coef_2 is a 16-bit two's-complement offset. The partner sample is ignored.
- R5: In matrix mode (`MODE` = IQC_MATRIX), the result is floor((I × coef_1 + Q × coef_2) / 2^14). The rounding is applied once, to the sum.
- R6: Pairing: with `ODD_CH` = 0 (master), I is `s_own` and Q is `s_pair`. With `ODD_CH` = 1 (slave), I is `s_pair` and Q is `s_own`.
- R7: Any result above 32767 is output as 0x7FFF. Any result below -32768 is output as 0x8000.
- R8: Coefficients are captured in the cycle where `enable` is high and was low in the previous cycle. A sample accepted in that same cycle already uses the new pair. Changes on `coef_1`/`coef_2` while `enable` stays high have no effect.
- R9: After synchronous active-low reset, `m_valid` is 0, `m_data` is 0 and the held coefficients are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Correction enable; its rising edge captures coefficients |
| coef_1 | input | 16 | Gain (scale mode) or I coefficient (matrix mode), 1.1.14 |
| coef_2 | input | 16 | Offset (scale mode) or Q coefficient (matrix mode) |
| s_valid | input | 1 | Sample strobe |
| s_own | input | 16 | This channel's signed sample |
| s_pair | input | 16 | Partner channel's signed sample |
| m_valid | output | 1 | Result strobe, two cycles after `s_valid` |
| m_data | output | 16 | Corrected signed sample |

## Verification
The assertions assume reset is held long enough to clear the pipeline with `s_valid` and `enable` low. They also assume the two sample inputs are meaningful only while `s_valid` is high. The stimulus drives everything on the falling clock edge, keeps `enable` low through reset, and lowers `enable` for at least one full cycle before each new coefficient load. Coefficient and sample values are chosen to reach both saturation limits, negative flooring, the unity gain and the case where a load coincides with a sample.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

   typedef enum logic [0:0] {
      IQC_SCALE_OFF = 1'b0,
      IQC_MATRIX    = 1'b1
   } iqc_mode_e;

endpackage

// File: rtl/iqc_coef_hold.sv
module iqc_coef_hold #(
   parameter int COEF_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic signed [COEF_W-1:0] k1_in,
   input  logic signed [COEF_W-1:0] k2_in,
   output logic signed [COEF_W-1:0] k1_use,
   output logic signed [COEF_W-1:0] k2_use
);

   logic                     en_d;
   logic                     en_rise;
   logic signed [COEF_W-1:0] k1_q;
   logic signed [COEF_W-1:0] k2_q;

   assign en_rise = enable & ~en_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_d <= 1'b0;
         k1_q <= '0;
         k2_q <= '0;
      end else begin
         en_d <= enable;
         if (en_rise) begin
            k1_q <= k1_in;
            k2_q <= k2_in;
         end
      end
   end

   // a load edge forwards the incoming pair so the same-cycle sample sees it
   assign k1_use = en_rise ? k1_in : k1_q;
   assign k2_use = en_rise ? k2_in : k2_q;

   // R8: while enable stays high the pair in use never moves
   p_coef_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && $past(rst_n)) |-> ($stable(k1_use) && $stable(k2_use)))
      else $error("coefficient pair changed while enable held");

endmodule

// File: rtl/iqc_term_gen.sv
module iqc_term_gen
   import iqc_pkg::*;
#(
   parameter int        DATA_W = 16,
   parameter int        COEF_W = 16,
   parameter int        FRAC_W = 14,
   parameter iqc_mode_e MODE   = IQC_MATRIX,
   parameter bit        ODD_CH = 1'b0,
   localparam int       TW     = DATA_W + COEF_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     bypass,
   input  logic signed [DATA_W-1:0] own,
   input  logic signed [DATA_W-1:0] pair,
   input  logic signed [COEF_W-1:0] k1,
   input  logic signed [COEF_W-1:0] k2,
   output logic                     out_valid,
   output logic signed [TW-1:0]     term_a,
   output logic signed [TW-1:0]     term_b
);

   logic signed [TW-1:0] own_x;
   logic signed [TW-1:0] k1_x;
   logic signed [TW-1:0] k2_x;
   logic signed [TW-1:0] mode_a;
   logic signed [TW-1:0] mode_b;
   logic signed [TW-1:0] nxt_a;
   logic signed [TW-1:0] nxt_b;

   assign own_x = TW'(own);
   assign k1_x  = TW'(k1);
   assign k2_x  = TW'(k2);

   generate
      if (MODE == IQC_SCALE_OFF) begin : g_scale
         logic unused_pair;
         assign unused_pair = ^pair;
         assign mode_a = own_x * k1_x;
         // offset lifted to the product's binary point so one shift serves both
         assign mode_b = k2_x <<< FRAC_W;
      end else begin : g_matrix
         logic signed [TW-1:0] pair_x;
         logic signed [TW-1:0] i_x;
         logic signed [TW-1:0] q_x;
         assign pair_x = TW'(pair);
         if (ODD_CH) begin : g_slave
            assign i_x = pair_x;
            assign q_x = own_x;
         end else begin : g_master
            assign i_x = own_x;
            assign q_x = pair_x;
         end
         assign mode_a = i_x * k1_x;
         assign mode_b = q_x * k2_x;
      end
   endgenerate

   always_comb begin
      if (bypass) begin
         nxt_a = own_x <<< FRAC_W;
         nxt_b = '0;
      end else begin
         nxt_a = mode_a;
         nxt_b = mode_b;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         term_a    <= '0;
         term_b    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            term_a <= nxt_a;
            term_b <= nxt_b;
         end
      end
   end

   // R3: a bypassed sample leaves the second term empty
   p_bypass_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bypass) |=> (out_valid && term_b == '0))
      else $error("bypass left a nonzero second term");

endmodule

// File: rtl/iqc_sum_sat.sv
module iqc_sum_sat #(
   parameter int  DATA_W = 16,
   parameter int  COEF_W = 16,
   parameter int  FRAC_W = 14,
   localparam int TW     = DATA_W + COEF_W + 1,
   localparam int SW     = TW + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     t_valid,
   input  logic signed [TW-1:0]     term_a,
   input  logic signed [TW-1:0]     term_b,
   output logic                     m_valid,
   output logic signed [DATA_W-1:0] m_data
);

   localparam logic signed [SW-1:0]     LIM_HI = SW'((2 ** (DATA_W - 1)) - 1);
   localparam logic signed [SW-1:0]     LIM_LO = -LIM_HI - SW'(1);
   localparam logic signed [DATA_W-1:0] OUT_HI = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] OUT_LO = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [SW-1:0]     acc;
   logic signed [SW-1:0]     scaled;
   logic signed [DATA_W-1:0] clipped;

   assign acc    = SW'(term_a) + SW'(term_b);
   assign scaled = acc >>> FRAC_W;

   always_comb begin
      if (scaled > LIM_HI)
         clipped = OUT_HI;
      else if (scaled < LIM_LO)
         clipped = OUT_LO;
      else
         clipped = scaled[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_data  <= '0;
      end else begin
         m_valid <= t_valid;
         if (t_valid)
            m_data <= clipped;
      end
   end

   // R2: no incoming term, no change on the output word
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !t_valid |=> $stable(m_data))
      else $error("output moved without a new result");

   // R7: overflow in either direction lands on the matching limit
   p_sat_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (t_valid && term_a >= 0 && term_b >= 0 && scaled > LIM_HI) |=> (m_data == OUT_HI))
      else $error("positive overflow not clipped");

   p_sat_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (t_valid && term_a < 0 && term_b < 0 && scaled < LIM_LO) |=> (m_data == OUT_LO))
      else $error("negative overflow not clipped");

endmodule

// File: rtl/iqc_stage.sv
module iqc_stage
   import iqc_pkg::*;
#(
   parameter int        DATA_W = 16,
   parameter int        COEF_W = 16,
   parameter int        FRAC_W = 14,
   parameter iqc_mode_e MODE   = IQC_MATRIX,
   parameter bit        ODD_CH = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable,
   input  logic signed [COEF_W-1:0] coef_1,
   input  logic signed [COEF_W-1:0] coef_2,
   input  logic                     s_valid,
   input  logic signed [DATA_W-1:0] s_own,
   input  logic signed [DATA_W-1:0] s_pair,
   output logic                     m_valid,
   output logic signed [DATA_W-1:0] m_data
);

   localparam int TW = DATA_W + COEF_W + 1;

   initial begin
      assert (FRAC_W > 0 && FRAC_W < COEF_W)
         else $fatal(1, "FRAC_W must leave sign and integer bits in the coefficient");
      assert (DATA_W >= 2 && COEF_W >= 2)
         else $fatal(1, "sample and coefficient widths too small");
   end

   logic signed [COEF_W-1:0] k1_use;
   logic signed [COEF_W-1:0] k2_use;
   logic                     t_valid;
   logic signed [TW-1:0]     term_a;
   logic signed [TW-1:0]     term_b;

   iqc_coef_hold #(
      .COEF_W (COEF_W)
   ) u_coef (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .k1_in  (coef_1),
      .k2_in  (coef_2),
      .k1_use (k1_use),
      .k2_use (k2_use)
   );

   iqc_term_gen #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .FRAC_W (FRAC_W),
      .MODE   (MODE),
      .ODD_CH (ODD_CH)
   ) u_terms (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s_valid),
      .bypass    (~enable),
      .own       (s_own),
      .pair      (s_pair),
      .k1        (k1_use),
      .k2        (k2_use),
      .out_valid (t_valid),
      .term_a    (term_a),
      .term_b    (term_b)
   );

   iqc_sum_sat #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .FRAC_W (FRAC_W)
   ) u_sum (
      .clk     (clk),
      .rst_n   (rst_n),
      .t_valid (t_valid),
      .term_a  (term_a),
      .term_b  (term_b),
      .m_valid (m_valid),
      .m_data  (m_data)
   );

   // R1: every accepted sample yields a result exactly two edges later
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |-> ##2 m_valid)
      else $error("result strobe missing two cycles after a sample");

   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |-> ##2 !m_valid)
      else $error("result strobe without a sample");

   // R3: with enable low the sample reappears unchanged
   p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && !enable) |-> ##2 (m_data == $past(s_own, 2)))
      else $error("bypassed sample altered");

endmodule

// File: tb/sim_iqc_stage.sv
`timescale 1ns/1ps
module sim_iqc_stage;
   import iqc_pkg::*;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               enable = 1'b0;
   logic signed [15:0] coef_1 = '0;
   logic signed [15:0] coef_2 = '0;
   logic               s_valid = 1'b0;
   logic signed [15:0] s_own = '0;
   logic signed [15:0] s_pair = '0;

   logic               mv0, mv1, mv2;
   logic signed [15:0] md0, md1, md2;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench-side record of the pair the design should be using
   bit                 e_en = 1'b0;
   logic signed [15:0] e_k1 = '0;
   logic signed [15:0] e_k2 = '0;

   always #2.5 clk = ~clk;

   // u0: matrix master, u1: matrix slave, u2: scale-and-offset master
   iqc_stage u0 (.clk(clk), .rst_n(rst_n), .enable(enable), .coef_1(coef_1), .coef_2(coef_2),
                 .s_valid(s_valid), .s_own(s_own), .s_pair(s_pair), .m_valid(mv0), .m_data(md0));
   iqc_stage #(.MODE(IQC_MATRIX), .ODD_CH(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .enable(enable),
                 .coef_1(coef_1), .coef_2(coef_2), .s_valid(s_valid), .s_own(s_own),
                 .s_pair(s_pair), .m_valid(mv1), .m_data(md1));
   iqc_stage #(.MODE(IQC_SCALE_OFF), .ODD_CH(1'b0)) u2 (.clk(clk), .rst_n(rst_n), .enable(enable),
                 .coef_1(coef_1), .coef_2(coef_2), .s_valid(s_valid), .s_own(s_own),
                 .s_pair(s_pair), .m_valid(mv2), .m_data(md2));

   function automatic logic signed [15:0] clip(input longint v);
      if (v > 32767) return 16'sh7FFF;
      if (v < -32768) return 16'sh8000;
      return 16'(v);
   endfunction

   // kind 0: matrix master, 1: matrix slave, 2: scale
   function automatic logic signed [15:0] model(input int kind, input bit en,
      input logic signed [15:0] own, input logic signed [15:0] pr,
      input logic signed [15:0] k1, input logic signed [15:0] k2);
      longint o, p, a, b;
      o = longint'(own); p = longint'(pr); a = longint'(k1); b = longint'(k2);
      if (!en) return own;
      case (kind)
         0:       return clip((o * a + p * b) >>> 14);
         1:       return clip((p * a + o * b) >>> 14);
         default: return clip(((o * a) >>> 14) + b);
      endcase
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic signed [15:0] own,
                            input logic signed [15:0] pr);
      chk({req, " u0 valid"}, mv0, 1);
      chk({req, " u0 data"}, md0, model(0, e_en, own, pr, e_k1, e_k2));
      chk({req, " u1 data"}, md1, model(1, e_en, own, pr, e_k1, e_k2));
      chk({req, " u2 data"}, md2, model(2, e_en, own, pr, e_k1, e_k2));
   endtask

   task automatic send(input string req, input logic signed [15:0] own,
                       input logic signed [15:0] pr);
      @(negedge clk); s_valid = 1'b1; s_own = own; s_pair = pr;
      @(negedge clk); s_valid = 1'b0; s_own = ~own; s_pair = ~pr;
      chk({req, " R1 not yet valid"}, mv0, 0);
      @(negedge clk);
      check_all(req, own, pr);
   endtask

   task automatic load(input logic signed [15:0] k1, input logic signed [15:0] k2);
      @(negedge clk); enable = 1'b0;
      @(negedge clk); enable = 1'b1; coef_1 = k1; coef_2 = k2;
      e_en = 1'b1; e_k1 = k1; e_k2 = k2;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9 reset valid", mv0, 0);
      chk("R9 reset data", md0, 0);
      chk("R9 reset data u2", md2, 0);
   endtask

   task automatic t_bypass;
      enable = 1'b0; e_en = 1'b0;
      coef_1 = 16'sh1234; coef_2 = 16'sh0777;
      send("R3 bypass pos", 16'sd1234, 16'sd99);
      send("R3 bypass neg", -16'sd32768, 16'sd5);
   endtask

   task automatic t_functions;
      load(16'sh4000, 16'sh0010);
      send("R4 R5 R6 unity", 16'sd1000, 16'sd200);
      load(16'sh2000, -16'sh1000);
      send("R4 R5 R6 half", -16'sd777, 16'sd3001);
      send("R5 floor negative", -16'sd1, 16'sd0);
      load(-16'sh6000, 16'sh7000);
      send("R5 R6 mixed", 16'sd12345, -16'sd23456);
   endtask

   task automatic t_saturate;
      load(16'sh7FFF, 16'sh7FFF);
      send("R7 high", 16'sd32767, 16'sd32767);
      send("R7 low", -16'sd32768, -16'sd32768);
      load(-16'sh8000, 16'sh0100);
      send("R7 scale max", -16'sd32768, 16'sd0);
   endtask

   task automatic t_coef_capture;
      load(16'sh4000, 16'sh0000);
      @(negedge clk); coef_1 = 16'sh1000; coef_2 = 16'sh3000;
      send("R8 change ignored", 16'sd4000, 16'sd2000);
      @(negedge clk); enable = 1'b0;
      @(negedge clk);
      enable = 1'b1; coef_1 = 16'sh2000; coef_2 = 16'sh6000;
      s_valid = 1'b1; s_own = 16'sd800; s_pair = -16'sd400;
      e_en = 1'b1; e_k1 = 16'sh2000; e_k2 = 16'sh6000;
      @(negedge clk); s_valid = 1'b0;
      @(negedge clk);
      check_all("R8 same-cycle load", 16'sd800, -16'sd400);
   endtask

   task automatic t_stream;
      logic signed [15:0] own_v [4];
      logic signed [15:0] pr_v [4];
      logic signed [15:0] last;
      own_v = '{16'sd100, -16'sd200, 16'sd300, 16'sd32000};
      pr_v  = '{16'sd7, 16'sd8, -16'sd9000, 16'sd32000};
      load(16'sh5000, 16'sh3000);
      for (int t = 0; t < 6; t++) begin
         @(negedge clk);
         if (t >= 2) check_all("R1 stream", own_v[t-2], pr_v[t-2]);
         if (t < 4) begin
            s_valid = 1'b1; s_own = own_v[t]; s_pair = pr_v[t];
         end else begin
            s_valid = 1'b0;
         end
      end
      last = md0;
      @(negedge clk); s_own = 16'sd1; s_pair = 16'sd1;
      @(negedge clk);
      chk("R1 idle valid", mv0, 0);
      chk("R2 hold", md0, last);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bypass();
      t_functions();
      t_saturate();
      t_coef_capture();
      t_stream();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule